// File: doc/BRIEF.md
# Host Bus to Shared Memory Bridge

This block lets a 32-bit synchronous host processor reach control registers, internal SRAM and shared memory. Several internal consumers also use that memory, and the host ranks lowest among them. Every host signal is sampled and driven on the single system clock.

When the host strobes an access, the block latches the address and the transfer direction. It then raises a request toward the memory arbiter and holds the host in wait states. Once the arbiter grants the bus, the block opens the address and data path. It then completes one data beat per active-low ready pulse.

A beat completes only when three things are true:
- memory reports that it is done;
- the host is not holding its active-low wait input;
- no configured post-first-beat gap is pending.

Bursts run until a beat that completes with the active-low last input asserted. After that beat the block drops its request and its path enable. The arbiter's policy and the memory timing are outside the block; they appear only as a grant input and a done input.

Top module: `hostbus_bridge`

## Requirements
- R1: While reset is held and directly after it, `arb_req` and `mem_en` and `mem_we` are low and `hst_rdy_n` is high.
- R2: A low `hst_ads_n` while idle raises `arb_req` after the next clock edge. `arb_req` then stays high until the clock edge that completes the beat carrying `hst_last_n` low.
- R3: While the grant has not yet been seen, `mem_en` is low and `hst_rdy_n` stays high; the host waits for as many cycles as the grant takes.
- R4: The clock edge that samples `arb_gnt` high turns `mem_en` on, and it stays on for every beat of the burst.
- R5: `hst_rdy_n` is low in exactly the cycles in which a beat completes. A beat completes when the bridge is transferring, `mem_done` is high, `hst_wait_n` is high and no gap is pending. The first beat completes one cycle after the grant edge at the earliest.
- R6: While `hst_wait_n` is low, no beat completes; each cycle it is held low delays the beat by one cycle.
- R7: After a beat that completes with `hst_last_n` low, the next cycle shows `arb_req` and `mem_en` low.
- R8: With `cfg_first_gap` high, exactly one cycle without ready is inserted between the first and second beats of a burst of two or more beats. No cycle is added before later beats, and none is added for a single-beat access.
- R9: `mem_addr` equals the latched start address on the first beat. It grows by 4 on each following beat, modulo 2^ADDR_W.
- R10: On a read beat, `hst_rdata` carries `mem_rdata` in the ready cycle. On a write beat, `mem_we` is high only in the ready cycle, with `mem_wdata` equal to `hst_wdata`.
- R11: A low `hst_ads_n` while a burst is in progress is ignored; the burst's address sequence is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_first_gap | input | 1 | Adds one wait after the first beat of a burst |
| hst_ads_n | input | 1 | Host access start strobe, active low |
| hst_addr | input | ADDR_W | Host byte address of the first beat |
| hst_write | input | 1 | 1 = write access, 0 = read access |
| hst_wdata | input | DATA_W | Host write data |
| hst_wait_n | input | 1 | Host-inserted wait, active low |
| hst_last_n | input | 1 | Marks the final beat of a burst, active low |
| hst_rdy_n | output | 1 | Beat completion strobe, active low |
| hst_rdata | output | DATA_W | Read data to the host, valid while ready is low |
| arb_req | output | 1 | Memory request to the arbiter |
| arb_gnt | input | 1 | Memory grant from the arbiter |
| mem_en | output | 1 | Address and data path enable |
| mem_addr | output | ADDR_W | Current beat address |
| mem_we | output | 1 | Write commit strobe |
| mem_wdata | output | DATA_W | Write data to memory |
| mem_rdata | input | DATA_W | Read data from memory |
| mem_done | input | 1 | Memory has finished the current beat |

## Verification
The bench builds the bridge with ADDR_W = 12 and DATA_W = 32. The narrow address lets a burst that starts at 0xFF8 carry the beat address over the top of the range, so the modulo increment of R9 is reached within a few beats. Beat timing is covered by a variable grant delay, stalls from the host wait input and from memory done, and the first-beat gap on both single and multi-beat accesses. Together these check that each ready pulse lands in the cycle the requirements predict.

// File: rtl/hb_pkg.sv
// Shared types for the host bus bridge.
// Assumes: a single clock domain; all users import this package.
package hb_pkg;
    typedef enum logic [1:0] {
        HB_IDLE    = 2'd0,
        HB_WAITGNT = 2'd1,
        HB_XFER    = 2'd2
    } hb_state_e;
endpackage

// File: rtl/hb_ctrl.sv
// Sequencer of the bridge: accepts an access, requests the memory,
// gates beat completion, and inserts the optional first-beat gap.
// Assumes: the grant is held for the whole burst once given.
module hb_ctrl
    import hb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_n,
    input  logic gnt,
    input  logic done,
    input  logic wait_n,
    input  logic last_n,
    input  logic gap_cfg,
    output logic accept,
    output logic busy,
    output logic path_en,
    output logic beat_fire
);
    hb_state_e state_q;
    logic      first_q;
    logic      gap_q;

    // Decode the control strobes from the current state.
    always_comb begin
        accept    = (state_q == HB_IDLE) && !start_n;
        busy      = (state_q != HB_IDLE);
        path_en   = (state_q == HB_XFER);
        beat_fire = path_en && done && wait_n && !gap_q;
    end

    // State transitions between idle, waiting for grant, and transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HB_IDLE;
        end else begin
            case (state_q)
                HB_IDLE:    if (accept) state_q <= HB_WAITGNT;
                HB_WAITGNT: if (gnt) state_q <= HB_XFER;
                HB_XFER:    if (beat_fire && !last_n) state_q <= HB_IDLE;
                default:    state_q <= HB_IDLE;
            endcase
        end
    end

    // Track the first beat and raise a one-cycle gap after it when configured.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b0;
            gap_q   <= 1'b0;
        end else begin
            if (accept) begin
                first_q <= 1'b1;
            end else if (beat_fire) begin
                first_q <= 1'b0;
            end
            gap_q <= beat_fire && first_q && gap_cfg && last_n;
        end
    end
endmodule

// File: rtl/hb_addr.sv
// Beat address generator: loads the start address on accept and
// advances by one data word after each completed beat.
// Assumes: byte addressing; the increment wraps at the top of the range.
module hb_addr #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              load_wr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              is_wr
);
    localparam int                STEP_BYTES = DATA_W / 8;
    localparam logic [ADDR_W-1:0] STEP       = ADDR_W'(STEP_BYTES);

    // Hold the beat address and the direction of the current access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr  <= '0;
            is_wr <= 1'b0;
        end else if (load) begin
            addr  <= load_addr;
            is_wr <= load_wr;
        end else if (step) begin
            addr  <= addr + STEP;
        end
    end
endmodule

// File: rtl/hb_data.sv
// Data steering: routes memory read data to the host on read beats and
// raises the write commit on write beats.
// Assumes: the beat strobe is high only in the ready cycle.
module hb_data #(
    parameter int DATA_W = 32
) (
    input  logic              fire,
    input  logic              is_wr,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] rdata_in,
    output logic [DATA_W-1:0] wdata_out,
    output logic [DATA_W-1:0] rdata_out,
    output logic              we
);
    // Steer data and write strobe for the current beat.
    always_comb begin
        we        = fire && is_wr;
        wdata_out = wdata_in;
        rdata_out = (fire && !is_wr) ? rdata_in : '0;
    end
endmodule

// File: rtl/hostbus_bridge.sv
// Top of the host bus bridge: connects a synchronous host bus to a shared
// memory through an arbitration request/grant pair.
// Assumes: the arbiter keeps the grant until the request falls.
module hostbus_bridge #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_first_gap,
    input  logic              hst_ads_n,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic              hst_write,
    input  logic [DATA_W-1:0] hst_wdata,
    input  logic              hst_wait_n,
    input  logic              hst_last_n,
    output logic              hst_rdy_n,
    output logic [DATA_W-1:0] hst_rdata,
    output logic              arb_req,
    input  logic              arb_gnt,
    output logic              mem_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_done
);
    logic accept;
    logic fire;
    logic is_wr;

    hb_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_n   (hst_ads_n),
        .gnt       (arb_gnt),
        .done      (mem_done),
        .wait_n    (hst_wait_n),
        .last_n    (hst_last_n),
        .gap_cfg   (cfg_first_gap),
        .accept    (accept),
        .busy      (arb_req),
        .path_en   (mem_en),
        .beat_fire (fire)
    );

    hb_addr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_addr (hst_addr),
        .load_wr   (hst_write),
        .step      (fire),
        .addr      (mem_addr),
        .is_wr     (is_wr)
    );

    hb_data #(.DATA_W(DATA_W)) u_data (
        .fire      (fire),
        .is_wr     (is_wr),
        .wdata_in  (hst_wdata),
        .rdata_in  (mem_rdata),
        .wdata_out (mem_wdata),
        .rdata_out (hst_rdata),
        .we        (mem_we)
    );

    // Ready is the inverted beat completion strobe.
    always_comb hst_rdy_n = !fire;
endmodule

// File: rtl/hb_chk.sv
// Protocol checker for the host bus bridge, attached by bind.
// Assumes: observes the top-level ports only.
module hb_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hst_rdy_n,
    input logic              hst_wait_n,
    input logic              hst_last_n,
    input logic              arb_req,
    input logic              mem_en,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

    // R2
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_req && !(!hst_rdy_n && !hst_last_n)) |=> arb_req);

    // R3
    no_rdy_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_en |-> hst_rdy_n);

    // R6
    wait_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hst_wait_n |-> hst_rdy_n);

    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hst_rdy_n && !hst_last_n) |=> (!arb_req && !mem_en));

    // R9
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hst_rdy_n && hst_last_n) |=> (mem_addr == $past(mem_addr) + STEP));

    // R10
    we_in_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !hst_rdy_n);
endmodule

bind hostbus_bridge hb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hb_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hst_rdy_n  (hst_rdy_n),
    .hst_wait_n (hst_wait_n),
    .hst_last_n (hst_last_n),
    .arb_req    (arb_req),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr)
);

// File: tb/test_hostbus_bridge.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues the expected beats, the monitor
// pops and compares each one in the cycle its ready pulse appears.
module test_hostbus_bridge;
    localparam int AW = 12;
    localparam int DW = 32;

    typedef struct packed {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic          w;
    } beat_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_first_gap = 1'b0;
    logic          hst_ads_n = 1'b1;
    logic [AW-1:0] hst_addr = '0;
    logic          hst_write = 1'b0;
    logic [DW-1:0] hst_wdata = '0;
    logic          hst_wait_n = 1'b1;
    logic          hst_last_n = 1'b1;
    logic          hst_rdy_n;
    logic [DW-1:0] hst_rdata;
    logic          arb_req;
    logic          arb_gnt = 1'b0;
    logic          mem_en;
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          mem_done = 1'b1;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    ended = 1'b0;
    beat_t exp_q[$];

    function automatic logic [DW-1:0] rd_model(logic [AW-1:0] a);
        return 32'h5A00_0000 ^ {8'h0, a, a};
    endfunction

    assign mem_rdata = rd_model(mem_addr);

    always #2.5 clk = ~clk;

    hostbus_bridge #(.ADDR_W(AW), .DATA_W(DW)) i_hostbus_bridge (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_first_gap (cfg_first_gap),
        .hst_ads_n     (hst_ads_n),
        .hst_addr      (hst_addr),
        .hst_write     (hst_write),
        .hst_wdata     (hst_wdata),
        .hst_wait_n    (hst_wait_n),
        .hst_last_n    (hst_last_n),
        .hst_rdy_n     (hst_rdy_n),
        .hst_rdata     (hst_rdata),
        .arb_req       (arb_req),
        .arb_gnt       (arb_gnt),
        .mem_en        (mem_en),
        .mem_addr      (mem_addr),
        .mem_we        (mem_we),
        .mem_wdata     (mem_wdata),
        .mem_rdata     (mem_rdata),
        .mem_done      (mem_done)
    );

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!ended) begin
            ended = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Monitor: compares every ready beat with the head of the queue.
    always @(negedge clk) begin
        #2;
        if (rst_n && !ended) begin
            if (!hst_rdy_n) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5", 32'(mem_addr), 32'hFFFF_FFFF);
                end else begin
                    beat_t e;
                    e = exp_q.pop_front();
                    chk(mem_addr == e.a, "R9", 32'(mem_addr), 32'(e.a));
                    chk(mem_en, "R4", 32'(mem_en), 32'd1);
                    if (e.w) begin
                        chk(mem_we && mem_wdata == e.d, "R10", mem_wdata, e.d);
                    end else begin
                        chk(!mem_we && hst_rdata == e.d, "R10", hst_rdata, e.d);
                    end
                end
            end else if (mem_we) begin
                chk(1'b0, "R10", 32'(mem_we), 32'd0);
            end
        end
    end

    task automatic prep(logic [AW-1:0] a, int i, int n, bit wr);
        beat_t e;
        logic [AW-1:0] ba;
        ba = a + AW'(4 * i);
        hst_last_n = (i == n - 1) ? 1'b0 : 1'b1;
        hst_wdata  = 32'hD000_0000 + 32'(i * 32'h111) + 32'(a);
        e.a = ba;
        e.w = wr;
        e.d = wr ? hst_wdata : rd_model(ba);
        exp_q.push_back(e);
    endtask

    // Driver: one access of n beats with grant delay, one stalled beat
    // (skind 0 = host wait, 1 = memory not done), gap config, and an
    // optional stray start strobe in the middle of the burst.
    task automatic burst(logic [AW-1:0] a, int n, bit wr, int gdelay,
                         int sbeat, int slen, bit skind, bit gap, bit mid);
        int  cyc;
        int  base;
        int  expc;
        bit  fired;
        bit  stall;
        string tag;
        @(negedge clk);
        cfg_first_gap = gap;
        hst_ads_n = 1'b0;
        hst_addr  = a;
        hst_write = wr;
        prep(a, 0, n, wr);
        @(negedge clk);
        hst_ads_n = 1'b1;
        #2;
        chk(arb_req, "R2", 32'(arb_req), 32'd1);
        for (int k = 0; k < gdelay; k++) begin
            @(negedge clk);
            #2;
            chk(hst_rdy_n && !mem_en, "R3", {30'd0, hst_rdy_n, mem_en}, 32'd2);
        end
        @(negedge clk);
        arb_gnt = 1'b1;
        for (int i = 0; i < n; i++) begin
            if (i > 0) begin
                @(negedge clk);
                prep(a, i, n, wr);
            end
            base = (i == 0) ? 1 : ((i == 1 && gap) ? 1 : 0);
            expc = base + ((i == sbeat) ? slen : 0);
            cyc = 0;
            fired = 1'b0;
            while (!fired && cyc < 40) begin
                if (cyc > 0) @(negedge clk);
                stall = (i == sbeat) && (cyc >= base) && (cyc < base + slen);
                hst_wait_n = !(stall && !skind);
                mem_done   = !(stall && skind);
                hst_ads_n  = !(mid && i == 1 && cyc == 0);
                if (!hst_ads_n) hst_addr = ~a;
                #2;
                fired = !hst_rdy_n;
                if (!fired) begin
                    chk(arb_req, "R2", 32'(arb_req), 32'd1);
                    cyc++;
                end
            end
            if (i == 1 && gap) tag = "R8";
            else if (i == sbeat && slen > 0) tag = skind ? "R5" : "R6";
            else tag = "R5";
            chk(cyc == expc, tag, 32'(cyc), 32'(expc));
        end
        @(negedge clk);
        arb_gnt    = 1'b0;
        hst_last_n = 1'b1;
        hst_wait_n = 1'b1;
        mem_done   = 1'b1;
        hst_ads_n  = 1'b1;
        #2;
        chk(!arb_req && !mem_en, "R7", {30'd0, arb_req, mem_en}, 32'd0);
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        #(200000 * 5);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        report();
    end

    // Stimulus sequence.
    initial begin
        repeat (3) @(negedge clk);
        #2;
        // R1: outputs idle while reset held
        chk(!arb_req && !mem_en && !mem_we && hst_rdy_n, "R1",
            {28'd0, arb_req, mem_en, mem_we, hst_rdy_n}, 32'd1);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk(!arb_req && !mem_en && !mem_we && hst_rdy_n, "R1",
            {28'd0, arb_req, mem_en, mem_we, hst_rdy_n}, 32'd1);
        // R2 R3 R4: single read, grant delayed three cycles
        burst(12'h100, 1, 1'b0, 3, -1, 0, 1'b0, 1'b0, 1'b0);
        // R9 R10: write burst, immediate grant
        burst(12'h200, 4, 1'b1, 0, -1, 0, 1'b0, 1'b0, 1'b0);
        // R8: read burst with the first-beat gap
        burst(12'h340, 4, 1'b0, 1, -1, 0, 1'b0, 1'b1, 1'b0);
        // R6 R11: host wait on beat 2, gap on, stray start strobe mid-burst
        burst(12'h480, 3, 1'b1, 2, 2, 3, 1'b0, 1'b1, 1'b1);
        // R5 R9: memory stall on first beat, address wrap at the top
        burst(12'hFF8, 3, 1'b0, 0, 0, 2, 1'b1, 1'b0, 1'b0);
        // R8: single write with gap enabled adds no wait
        burst(12'h020, 1, 1'b1, 1, -1, 0, 1'b0, 1'b1, 1'b0);
        // R6: host wait on the first beat
        burst(12'h600, 2, 1'b0, 0, 0, 2, 1'b0, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R5", 32'(exp_q.size()), 32'd0);
        report();
    end
endmodule